// File: doc/BRIEF.md
# Dual-Master Configuration Bridge

This block lets two independent masters program the same set of configuration registers. One master is the SoC processor, which issues classic Wishbone cycles. The other is a remote master on the FPGA side, which issues requests through a valid/ready request channel and receives answers on a valid/ready response channel. Each master has its own front-end state machine. That machine turns its accesses into AXI-Lite address, data and response phases. A one-bit grant register decides which front end currently drives the single internal AXI-Lite path. Value 0 means the SoC owns the path and value 1 means the FPGA side owns it.

At the far end of the path sits one AXI-Lite target. The target accepts a transaction only from its idle state. Offset 0x5000 holds a 5-bit project-select register, which is driven straight out of the block. Every other offset is passed unchanged to a user-project register port. The SoC reaches the register window through the Wishbone base 0x3000_0000. The FPGA side uses the bare 28-bit offset, so a SoC access to 0x3000_0000+X and an FPGA access to X reach the same register.

Back-pressure rules:
- Remote request channel: a request is taken on a cycle where `rm_req_valid` and `rm_req_ready` are both high. `rm_req_ready` stays low from that cycle until the response has been taken.
- Remote response channel: `rm_rsp_valid` and `rm_rsp_rdata` hold steady until `rm_rsp_ready` is high.
- User-port request channel: `up_req_valid` holds its payload until `up_req_ready` is high.
- User-port response: `up_rsp_valid` is a single-cycle pulse with no ready signal. The bridge accepts it only while it is waiting for that response.

Top module: `cfg_bridge_top`

## Requirements
- R1: A Wishbone access is claimed only when `wb_adr_i[31:28]` equals 4'h3. Its register offset is then `wb_adr_i[27:0]`, which is the same offset space the remote master addresses directly. An access with any other upper nibble gets no acknowledge and produces no user-port request.
- R2: A write to offset 0x5000 loads data bits [4:0] into `prj_sel` and is not forwarded to the user port. `prj_sel` changes on no other event.
- R3: A read of offset 0x5000 returns `prj_sel` zero-extended to 32 bits, whichever master issues it.
- R4: An access to any offset other than 0x5000 appears on the user port with the same offset, direction (`up_req_we` = 1 for a write) and write data. A read returns the `up_rsp_rdata` value that came back with `up_rsp_valid`.
- R5: After reset, `prj_sel` is 0, `up_req_valid`, `wb_ack_o` and `rm_rsp_valid` are low, and `rm_req_ready` is high.
- R6: Each access runs through AXI-Lite address, data and response phases. `wb_ack_o` is a one-cycle pulse, raised the cycle after the response handshake of its transaction, and `wb_dat_o` carries the read data in that cycle.
- R7: The remote request channel and response channel follow the back-pressure rules above.
- R8: When both masters wait for the free path in the same cycle, the grant goes to the master that did not win most recently.
- R9: Once granted, a master keeps the path until its response handshake completes. No other access reaches the user port while a forwarded access is still waiting for its user-port response.
- R10: The target takes a new transaction only when idle. A stalled user-port request keeps `up_req_valid`, offset, direction and data steady until `up_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 32 | Wishbone byte address |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| wb_dat_o | output | 32 | Wishbone read data |
| rm_req_valid | input | 1 | Remote request valid |
| rm_req_ready | output | 1 | Remote request ready |
| rm_req_we | input | 1 | Remote request is a write |
| rm_req_addr | input | 28 | Remote register offset |
| rm_req_wdata | input | 32 | Remote write data |
| rm_rsp_valid | output | 1 | Remote response valid |
| rm_rsp_ready | input | 1 | Remote response ready |
| rm_rsp_rdata | output | 32 | Remote read data |
| up_req_valid | output | 1 | User-port request valid |
| up_req_ready | input | 1 | User-port request ready |
| up_req_we | output | 1 | User-port request is a write |
| up_req_addr | output | 28 | User-port register offset |
| up_req_wdata | output | 32 | User-port write data |
| up_rsp_valid | input | 1 | User-port response pulse |
| up_rsp_rdata | input | 32 | User-port read data |
| prj_sel | output | 5 | Project-select register |

## Verification
The in-line properties check the following on every cycle:
- the grant and ownership stay stable until the response handshake, and only one master sees responses at a time;
- the select register changes only on an accepted write and is never exposed on the user port;
- the stall rules hold on the user-port, remote and initiator channels;
- `wb_ack_o` is a single pulse.

Only the bench's scenarios can show the following:
- that a given address lands at the right offset, and that both masters alias onto the same registers;
- the zero-extended read value;
- the alternating winner order under simultaneous requests;
- that an out-of-region Wishbone access is left unclaimed.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int CB_ADDR_W = 28;
  localparam int CB_DATA_W = 32;

  typedef logic [CB_ADDR_W-1:0] cb_addr_t;
  typedef logic [CB_DATA_W-1:0] cb_data_t;

  // Master-to-target half of the internal AXI-Lite path
  typedef struct packed {
    logic     aw_valid;
    cb_addr_t aw_addr;
    logic     w_valid;
    cb_data_t w_data;
    logic     b_ready;
    logic     ar_valid;
    cb_addr_t ar_addr;
    logic     r_ready;
  } axil_req_t;

  // Target-to-master half
  typedef struct packed {
    logic     aw_ready;
    logic     w_ready;
    logic     b_valid;
    logic     ar_ready;
    logic     r_valid;
    cb_data_t r_data;
  } axil_rsp_t;

  typedef enum logic [1:0] {INI_IDLE, INI_ADDR, INI_RESP} ini_state_e;
  typedef enum logic [1:0] {TGT_IDLE, TGT_UPREQ, TGT_UPWAIT, TGT_RESP} tgt_state_e;
endpackage

// File: rtl/cfg_axil_initiator.sv
module cfg_axil_initiator
  import cfg_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_we,
  input  cb_addr_t  start_addr,
  input  cb_data_t  start_wdata,
  output logic      want,
  output logic      done,
  output cb_data_t  done_rdata,
  output axil_req_t m_req,
  input  axil_rsp_t m_rsp
);
  ini_state_e state_q;
  logic       we_q;
  cb_addr_t   addr_q;
  cb_data_t   wdata_q;
  logic       addr_ok, resp_ok;

  assign addr_ok = we_q ? (m_rsp.aw_ready && m_rsp.w_ready) : m_rsp.ar_ready;
  assign resp_ok = we_q ? m_rsp.b_valid : m_rsp.r_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= INI_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        INI_IDLE: if (start) begin
          we_q    <= start_we;
          addr_q  <= start_addr;
          wdata_q <= start_wdata;
          state_q <= INI_ADDR;
        end
        INI_ADDR: if (addr_ok) state_q <= INI_RESP;
        INI_RESP: if (resp_ok) state_q <= INI_IDLE;
        default:  state_q <= INI_IDLE;
      endcase
    end
  end

  always_comb begin
    m_req          = '0;
    m_req.aw_valid = (state_q == INI_ADDR) && we_q;
    m_req.w_valid  = (state_q == INI_ADDR) && we_q;
    m_req.aw_addr  = addr_q;
    m_req.w_data   = wdata_q;
    m_req.ar_valid = (state_q == INI_ADDR) && !we_q;
    m_req.ar_addr  = addr_q;
    m_req.b_ready  = (state_q == INI_RESP) && we_q;
    m_req.r_ready  = (state_q == INI_RESP) && !we_q;
  end

  assign want       = (state_q == INI_ADDR);
  assign done       = (state_q == INI_RESP) && resp_ok;
  assign done_rdata = we_q ? '0 : m_rsp.r_data;

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req.aw_valid && !m_rsp.aw_ready) |=> (m_req.aw_valid && $stable(m_req.aw_addr) && $stable(m_req.w_data))); // R6
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req.ar_valid && !m_rsp.ar_ready) |=> (m_req.ar_valid && $stable(m_req.ar_addr))); // R6
endmodule

// File: rtl/cfg_path_arbiter.sv
module cfg_path_arbiter
  import cfg_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want_soc,
  input  logic      want_fpga,
  input  axil_req_t soc_req,
  input  axil_req_t fpga_req,
  output axil_rsp_t soc_rsp,
  output axil_rsp_t fpga_rsp,
  output axil_req_t tgt_req,
  input  axil_rsp_t tgt_rsp
);
  logic busy_q;
  logic grant_q;   // 0: SoC side, 1: FPGA side; also remembers last winner
  logic release_path;
  logic pick;

  assign release_path = busy_q &&
    ((tgt_req.b_ready && tgt_rsp.b_valid) || (tgt_req.r_ready && tgt_rsp.r_valid));
  assign pick = (want_soc && want_fpga) ? ~grant_q : want_fpga;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= 1'b1;  // first simultaneous request after reset goes to the SoC
    end else if (!busy_q) begin
      if (want_soc || want_fpga) begin
        busy_q  <= 1'b1;
        grant_q <= pick;
      end
    end else if (release_path) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    tgt_req  = '0;
    soc_rsp  = '0;
    fpga_rsp = '0;
    if (busy_q) begin
      if (grant_q) begin
        tgt_req  = fpga_req;
        fpga_rsp = tgt_rsp;
      end else begin
        tgt_req = soc_req;
        soc_rsp = tgt_rsp;
      end
    end
  end

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !release_path) |=> (busy_q && $stable(grant_q))); // R9
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({(soc_rsp.aw_ready | soc_rsp.ar_ready | soc_rsp.b_valid | soc_rsp.r_valid),
              (fpga_rsp.aw_ready | fpga_rsp.ar_ready | fpga_rsp.b_valid | fpga_rsp.r_valid)})); // R9
endmodule

// File: rtl/cfg_axil_target.sv
module cfg_axil_target
  import cfg_bridge_pkg::*;
#(
  parameter int       SEL_W      = 5,
  parameter cb_addr_t SEL_OFFSET = 28'h000_5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  axil_req_t        s_req,
  output axil_rsp_t        s_rsp,
  output logic             up_req_valid,
  input  logic             up_req_ready,
  output logic             up_req_we,
  output cb_addr_t         up_req_addr,
  output cb_data_t         up_req_wdata,
  input  logic             up_rsp_valid,
  input  cb_data_t         up_rsp_rdata,
  output logic [SEL_W-1:0] prj_sel
);
  localparam int PAD_W = CB_DATA_W - SEL_W;

  tgt_state_e       state_q;
  logic             is_wr_q;
  cb_addr_t         addr_q;
  cb_data_t         wdata_q, rdata_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_both, accept;
  cb_addr_t         acc_addr;

  assign wr_both  = s_req.aw_valid && s_req.w_valid;
  assign accept   = (state_q == TGT_IDLE) && (wr_both || s_req.ar_valid);
  assign acc_addr = wr_both ? s_req.aw_addr : s_req.ar_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TGT_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      sel_q   <= '0;
    end else begin
      unique case (state_q)
        TGT_IDLE: if (accept) begin
          is_wr_q <= wr_both;
          addr_q  <= acc_addr;
          wdata_q <= s_req.w_data;
          if (acc_addr == SEL_OFFSET) begin
            if (wr_both) sel_q <= s_req.w_data[SEL_W-1:0];
            rdata_q <= {{PAD_W{1'b0}}, sel_q};
            state_q <= TGT_RESP;
          end else begin
            state_q <= TGT_UPREQ;
          end
        end
        TGT_UPREQ:  if (up_req_ready) state_q <= TGT_UPWAIT;
        TGT_UPWAIT: if (up_rsp_valid) begin
          rdata_q <= up_rsp_rdata;
          state_q <= TGT_RESP;
        end
        TGT_RESP: if (is_wr_q ? s_req.b_ready : s_req.r_ready) state_q <= TGT_IDLE;
        default:  state_q <= TGT_IDLE;
      endcase
    end
  end

  always_comb begin
    s_rsp          = '0;
    s_rsp.aw_ready = (state_q == TGT_IDLE) && wr_both;
    s_rsp.w_ready  = (state_q == TGT_IDLE) && wr_both;
    s_rsp.ar_ready = (state_q == TGT_IDLE) && s_req.ar_valid && !wr_both;
    s_rsp.b_valid  = (state_q == TGT_RESP) && is_wr_q;
    s_rsp.r_valid  = (state_q == TGT_RESP) && !is_wr_q;
    s_rsp.r_data   = rdata_q;
  end

  assign up_req_valid = (state_q == TGT_UPREQ);
  assign up_req_we    = is_wr_q;
  assign up_req_addr  = addr_q;
  assign up_req_wdata = wdata_q;
  assign prj_sel      = sel_q;

  AST_SEL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_req.aw_valid && s_rsp.aw_ready) |=> $stable(prj_sel)); // R2
  AST_SEL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid |-> (up_req_addr != SEL_OFFSET)); // R4
  AST_UP_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && !up_req_ready) |=> (up_req_valid && $stable(up_req_addr) &&
                                         $stable(up_req_wdata) && $stable(up_req_we))); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rsp.b_valid || s_rsp.r_valid || up_req_valid) |-> !(s_rsp.aw_ready || s_rsp.ar_ready)); // R10
endmodule

// File: rtl/cfg_bridge_top.sv
module cfg_bridge_top
  import cfg_bridge_pkg::*;
#(
  parameter int                  SEL_W      = 5,
  parameter cb_addr_t            SEL_OFFSET = 28'h000_5000,
  parameter int                  REGION_W   = 4,
  parameter logic [REGION_W-1:0] REGION     = 4'h3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wb_cyc_i,
  input  logic                          wb_stb_i,
  input  logic                          wb_we_i,
  input  logic [CB_ADDR_W+REGION_W-1:0] wb_adr_i,
  input  logic [CB_DATA_W-1:0]          wb_dat_i,
  output logic                          wb_ack_o,
  output logic [CB_DATA_W-1:0]          wb_dat_o,
  input  logic                          rm_req_valid,
  output logic                          rm_req_ready,
  input  logic                          rm_req_we,
  input  logic [CB_ADDR_W-1:0]          rm_req_addr,
  input  logic [CB_DATA_W-1:0]          rm_req_wdata,
  output logic                          rm_rsp_valid,
  input  logic                          rm_rsp_ready,
  output logic [CB_DATA_W-1:0]          rm_rsp_rdata,
  output logic                          up_req_valid,
  input  logic                          up_req_ready,
  output logic                          up_req_we,
  output logic [CB_ADDR_W-1:0]          up_req_addr,
  output logic [CB_DATA_W-1:0]          up_req_wdata,
  input  logic                          up_rsp_valid,
  input  logic [CB_DATA_W-1:0]          up_rsp_rdata,
  output logic [SEL_W-1:0]              prj_sel
);
  localparam int WB_AW = CB_ADDR_W + REGION_W;

  // ---------------- SoC (Wishbone) front end ----------------
  logic      wb_hit, wb_start, wb_inflight_q, wb_ack_q, wb_done;
  cb_data_t  wb_dat_q, wb_rdata;
  logic      wb_want;
  axil_req_t wb_axreq;
  axil_rsp_t wb_axrsp;

  assign wb_hit   = wb_cyc_i && wb_stb_i && (wb_adr_i[WB_AW-1 -: REGION_W] == REGION);
  assign wb_start = wb_hit && !wb_inflight_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_inflight_q <= 1'b0;
      wb_ack_q      <= 1'b0;
      wb_dat_q      <= '0;
    end else begin
      if (wb_start)      wb_inflight_q <= 1'b1;
      else if (wb_ack_q) wb_inflight_q <= 1'b0;
      wb_ack_q <= wb_done;
      if (wb_done) wb_dat_q <= wb_rdata;
    end
  end

  assign wb_ack_o = wb_ack_q;
  assign wb_dat_o = wb_dat_q;

  cfg_axil_initiator u_soc_ini (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (wb_start),
    .start_we    (wb_we_i),
    .start_addr  (wb_adr_i[CB_ADDR_W-1:0]),
    .start_wdata (wb_dat_i),
    .want        (wb_want),
    .done        (wb_done),
    .done_rdata  (wb_rdata),
    .m_req       (wb_axreq),
    .m_rsp       (wb_axrsp)
  );

  // ---------------- FPGA-side (remote) front end ----------------
  logic      rm_busy_q, rm_start, rm_done, rm_want, rm_rsp_valid_q;
  cb_data_t  rm_rdata, rm_rdata_q;
  axil_req_t rm_axreq;
  axil_rsp_t rm_axrsp;

  assign rm_req_ready = !rm_busy_q;
  assign rm_start     = rm_req_valid && !rm_busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_busy_q      <= 1'b0;
      rm_rsp_valid_q <= 1'b0;
      rm_rdata_q     <= '0;
    end else begin
      if (rm_start) rm_busy_q <= 1'b1;
      if (rm_done) begin
        rm_rsp_valid_q <= 1'b1;
        rm_rdata_q     <= rm_rdata;
      end else if (rm_rsp_valid_q && rm_rsp_ready) begin
        rm_rsp_valid_q <= 1'b0;
        rm_busy_q      <= 1'b0;
      end
    end
  end

  assign rm_rsp_valid = rm_rsp_valid_q;
  assign rm_rsp_rdata = rm_rdata_q;

  cfg_axil_initiator u_fpga_ini (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rm_start),
    .start_we    (rm_req_we),
    .start_addr  (rm_req_addr),
    .start_wdata (rm_req_wdata),
    .want        (rm_want),
    .done        (rm_done),
    .done_rdata  (rm_rdata),
    .m_req       (rm_axreq),
    .m_rsp       (rm_axrsp)
  );

  // ---------------- Shared path ----------------
  axil_req_t tgt_req;
  axil_rsp_t tgt_rsp;

  cfg_path_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_soc  (wb_want),
    .want_fpga (rm_want),
    .soc_req   (wb_axreq),
    .fpga_req  (rm_axreq),
    .soc_rsp   (wb_axrsp),
    .fpga_rsp  (rm_axrsp),
    .tgt_req   (tgt_req),
    .tgt_rsp   (tgt_rsp)
  );

  cfg_axil_target #(
    .SEL_W      (SEL_W),
    .SEL_OFFSET (SEL_OFFSET)
  ) u_tgt (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_req        (tgt_req),
    .s_rsp        (tgt_rsp),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_req_we    (up_req_we),
    .up_req_addr  (up_req_addr),
    .up_req_wdata (up_req_wdata),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_rdata (up_rsp_rdata),
    .prj_sel      (prj_sel)
  );

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o); // R6
  AST_ACK_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i)); // R6
  AST_RM_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_rsp_valid && !rm_rsp_ready) |=> (rm_rsp_valid && $stable(rm_rsp_rdata))); // R7
  AST_RM_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rm_rsp_valid |-> !rm_req_ready); // R7
endmodule

// File: tb/cfg_bridge_top_bench.sv
`timescale 1ns/1ps
module cfg_bridge_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_cyc_i = 0, wb_stb_i = 0, wb_we_i = 0;
  logic [31:0] wb_adr_i = '0, wb_dat_i = '0;
  logic        wb_ack_o;
  logic [31:0] wb_dat_o;
  logic        rm_req_valid = 0, rm_req_we = 0, rm_rsp_ready = 0;
  logic [27:0] rm_req_addr = '0;
  logic [31:0] rm_req_wdata = '0;
  logic        rm_req_ready, rm_rsp_valid;
  logic [31:0] rm_rsp_rdata;
  logic        up_req_valid, up_req_we;
  logic        up_req_ready = 1'b1;
  logic [27:0] up_req_addr;
  logic [31:0] up_req_wdata;
  logic        up_rsp_valid = 1'b0;
  logic [31:0] up_rsp_rdata = '0;
  logic [4:0]  prj_sel;

  int checks = 0;
  int fails  = 0;
  int rsp_delay = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_bridge_top u_cfg_bridge_top (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_ack_o(wb_ack_o), .wb_dat_o(wb_dat_o),
    .rm_req_valid(rm_req_valid), .rm_req_ready(rm_req_ready), .rm_req_we(rm_req_we),
    .rm_req_addr(rm_req_addr), .rm_req_wdata(rm_req_wdata),
    .rm_rsp_valid(rm_rsp_valid), .rm_rsp_ready(rm_rsp_ready), .rm_rsp_rdata(rm_rsp_rdata),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_we(up_req_we),
    .up_req_addr(up_req_addr), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata),
    .prj_sel(prj_sel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] up_model(input logic [27:0] a);
    return {4'hC, a} ^ 32'h0F0F_0000;
  endfunction

  // scoreboard of expected user-port requests
  typedef struct {
    bit          we;
    logic [27:0] addr;
    logic [31:0] data;
  } exp_t;
  exp_t sb_q[$];

  task automatic expect_up(input bit we, input logic [27:0] a, input logic [31:0] d);
    exp_t e;
    e.we = we; e.addr = a; e.data = d;
    sb_q.push_back(e);
  endtask

  // monitor + user-project responder
  bit          mon_wait = 0, mon_viol = 0;
  int          mon_cnt = 0;
  logic [27:0] mon_addr = '0;
  always @(negedge clk) begin
    up_rsp_valid = 1'b0;
    if (rst_n) begin
      if (mon_wait) begin
        if (up_req_valid) mon_viol = 1'b1;
        if (mon_cnt == 0) begin
          up_rsp_valid = 1'b1;
          up_rsp_rdata = up_model(mon_addr);
          mon_wait = 1'b0;
          chk(!mon_viol, "R9 request while another waits", {31'b0, mon_viol}, 32'h0);
        end else begin
          mon_cnt--;
        end
      end else if (up_req_valid && up_req_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R4 unexpected user-port request", {4'h0, up_req_addr}, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(up_req_we == e.we && up_req_addr == e.addr && (!e.we || up_req_wdata == e.data),
              "R4 user-port request offset/dir/data", {4'h0, up_req_addr}, {4'h0, e.addr});
        end
        mon_wait = 1'b1;
        mon_cnt  = rsp_delay;
        mon_viol = 1'b0;
        mon_addr = up_req_addr;
      end
    end
  end

  task automatic wb_xfer(input bit we, input logic [31:0] adr, input logic [31:0] dat,
                         output logic [31:0] rd);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = we; wb_adr_i = adr; wb_dat_i = dat;
    do @(negedge clk); while (!wb_ack_o);
    rd = wb_dat_o;
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    @(negedge clk);
    chk(!wb_ack_o, "R6 ack is a single-cycle pulse", {31'b0, wb_ack_o}, 32'h0);
  endtask

  task automatic rm_xfer(input bit we, input logic [27:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    logic [31:0] first;
    @(negedge clk);
    rm_req_valid = 1; rm_req_we = we; rm_req_addr = a; rm_req_wdata = d;
    while (!rm_req_ready) @(negedge clk);
    @(negedge clk);
    rm_req_valid = 0;
    chk(!rm_req_ready, "R7 ready low while request outstanding", {31'b0, rm_req_ready}, 32'h0);
    while (!rm_rsp_valid) @(negedge clk);
    first = rm_rsp_rdata;
    @(negedge clk);
    chk(rm_rsp_valid && rm_rsp_rdata == first, "R7 response held without ready",
        rm_rsp_rdata, first);
    rm_rsp_ready = 1;
    rd = rm_rsp_rdata;
    @(negedge clk);
    rm_rsp_ready = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(prj_sel == 5'd0, "R5 prj_sel after reset", {27'b0, prj_sel}, 32'h0);
    chk(!up_req_valid && !wb_ack_o && !rm_rsp_valid && rm_req_ready, "R5 idle outputs",
        {28'b0, up_req_valid, wb_ack_o, rm_rsp_valid, rm_req_ready}, 32'h1);

    // R2 select write via SoC base
    wb_xfer(1, 32'h3000_5000, 32'hFFFF_FFF6, rd);
    chk(prj_sel == 5'h16, "R2 select written from data[4:0]", {27'b0, prj_sel}, 32'h16);
    // R3 read via FPGA offset
    rm_xfer(0, 28'h000_5000, 32'h0, rd);
    chk(rd == 32'h0000_0016, "R3 select read zero-extended (FPGA)", rd, 32'h16);
    rm_xfer(1, 28'h000_5000, 32'hABCD_0009, rd);
    chk(prj_sel == 5'h09, "R2 select written by FPGA master", {27'b0, prj_sel}, 32'h9);
    wb_xfer(0, 32'h3000_5000, 32'h0, rd);
    chk(rd == 32'h0000_0009, "R3 select read zero-extended (SoC)", rd, 32'h9);

    // R1/R4 forwarding with aliased offsets
    expect_up(1, 28'h010, 32'h1234_5678);
    wb_xfer(1, 32'h3000_0010, 32'h1234_5678, rd);
    expect_up(1, 28'h010, 32'h0000_CAFE);
    rm_xfer(1, 28'h010, 32'h0000_CAFE, rd);
    expect_up(0, 28'h048, 32'h0);
    wb_xfer(0, 32'h3000_0048, 32'h0, rd);
    chk(rd == up_model(28'h048), "R4 SoC read data from user port", rd, up_model(28'h048));
    expect_up(0, 28'h4FFC, 32'h0);
    rm_xfer(0, 28'h4FFC, 32'h0, rd);
    chk(rd == up_model(28'h4FFC), "R4 FPGA read data from user port", rd, up_model(28'h4FFC));
    expect_up(1, 28'h5004, 32'h0000_0077);
    rm_xfer(1, 28'h5004, 32'h0000_0077, rd);
    chk(prj_sel == 5'h09, "R2 neighbour offset leaves select", {27'b0, prj_sel}, 32'h9);

    // R1 out-of-region access is not claimed
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = 32'h2000_0010; wb_dat_i = 32'h5;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!wb_ack_o && !up_req_valid, "R1 out-of-region access unclaimed",
          {30'b0, wb_ack_o, up_req_valid}, 32'h0);
    end
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;

    // R8 tie after an FPGA win: SoC goes first
    expect_up(1, 28'h020, 32'h0000_0A01);
    expect_up(1, 28'h024, 32'h0000_0B01);
    fork
      wb_xfer(1, 32'h3000_0020, 32'h0000_0A01, rd);
      rm_xfer(1, 28'h024, 32'h0000_0B01, rd2);
    join
    expect_up(1, 28'h028, 32'h0000_0A02);
    wb_xfer(1, 32'h3000_0028, 32'h0000_0A02, rd);
    // R8 tie after a SoC win: FPGA goes first
    expect_up(1, 28'h030, 32'h0000_0B02);
    expect_up(1, 28'h02C, 32'h0000_0A03);
    fork
      wb_xfer(1, 32'h3000_002C, 32'h0000_0A03, rd);
      rm_xfer(1, 28'h030, 32'h0000_0B02, rd2);
    join
    chk(sb_q.size() == 0, "R8 arbitration order consumed", sb_q.size(), 32'h0);

    // R9 grant held across a slow user response
    rsp_delay = 6;
    expect_up(1, 28'h100, 32'h0000_1100);
    expect_up(1, 28'h104, 32'h0000_2200);
    fork
      wb_xfer(1, 32'h3000_0100, 32'h0000_1100, rd);
      begin @(negedge clk); rm_xfer(1, 28'h104, 32'h0000_2200, rd2); end
    join
    rsp_delay = 0;

    // R10 stalled user-port request keeps its payload
    up_req_ready = 1'b0;
    expect_up(1, 28'h200, 32'h0000_3300);
    fork
      wb_xfer(1, 32'h3000_0200, 32'h0000_3300, rd);
      begin
        do @(negedge clk); while (!up_req_valid);
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(up_req_valid && up_req_addr == 28'h200 && up_req_wdata == 32'h0000_3300 && up_req_we,
              "R10 stalled request held", {4'h0, up_req_addr}, 32'h200);
        end
        up_req_ready = 1'b1;
      end
    join

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4 all expected requests seen", sb_q.size(), 32'h0);
    chk(prj_sel == 5'h09, "R2 select untouched by forwarded traffic", {27'b0, prj_sel}, 32'h9);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule